// File: doc/BRIEF.md
# Transmitter Safety Fault Controller

This block supervises the two laser enables of an optical transmitter: the bias-current enable and the modulation-current enable. It watches a transmit-disable request and five fault flags that come from external comparators. All of these inputs are asynchronous. When a qualified fault appears, the block latches it, raises a fault output, records which sources caused it, and turns both enables off. A report-only input lets the fault be flagged while the laser keeps running.

After reset, and again after every clear, the block runs a timed initialization window. During that window the enables stay off and fault flags are ignored. Once the window ends, alarms are armed and the enables turn on. The latch is cleared by only one action: holding transmit-disable high for at least a minimum number of cycles and then dropping it. The block then re-initializes before it returns to normal operation.

All time intervals are given as clock-cycle counts. This lets an integrator set the real values, 25 ms of initialization and a hold of a few microseconds, from the clock frequency.

Top module: `tx_safety_supervisor`

## Requirements
- R1: While the synchronized transmit-disable is high, both enables are low. The disable synchronizer resets to the disabled level, so the input reads as high until real samples have passed through it.
- R2: After reset, or after a clear, the block waits in initialization for INIT_CYCLES cycles with transmit-disable low. During this wait the enables are low. When it ends with no fault present, both enables go high.
- R3: The fault output is active high and latched. It stays high after the fault flag that caused it goes low again.
- R4: While the fault output is high and report-only is low, both enables are low. While report-only is high and transmit-disable is low, a latched fault leaves both enables high.
- R5: A latched fault clears only when transmit-disable has been high for at least HOLD_CYCLES synchronized cycles and then goes low. A shorter high pulse leaves the fault set. After a clear, the block re-enters initialization.
- R6: The fault flag bits are: bit 0 bias over threshold, bit 1 photodiode above its upper bound, bit 2 photodiode below its lower bound, bit 3 bias-node undervoltage, bit 4 extinction reference shorted high. Bit 4 counts only while the voltage-setpoint mode input is high.
- R7: Every input passes through a two-flop synchronizer. A fault flag, or a rising edge on transmit-disable, driven before clock edge k changes the outputs at edge k+2.
- R8: The fault-source output holds the qualified flags present in the cycle the latch was set. It stays unchanged while the latch is set and is cleared together with the latch.
- R9: Fault flags are ignored while transmit-disable is high and during initialization. A qualified flag still present when initialization ends sets the latch in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_disable_i | input | 1 | Asynchronous transmit-disable request (high = laser off) |
| fault_flags_i | input | NUM_SRC | Asynchronous fault-condition flags, bit map per R6 |
| vset_mode_i | input | 1 | Voltage-setpoint mode select; qualifies flag bit 4 |
| report_only_i | input | 1 | High: a latched fault does not shut the enables off |
| fault_o | output | 1 | Latched fault indication |
| bias_en_o | output | 1 | Registered bias-current enable |
| mod_en_o | output | 1 | Registered modulation-current enable |
| fault_src_o | output | NUM_SRC | Sticky record of the sources that set the latch |

## Verification
The tests include single-cycle fault pulses and flags held high, to show that the latch and the source record are sticky and that the latency is exact. Disable pulses just shorter and just longer than the hold limit show which pulses clear the latch and which do not. Flags raised during initialization or while disabled are compared with a flag held across the end of initialization, which shows masking apart from immediate latching. The extinction-reference flag is tried with the mode input in both states, and a fault is raised with report-only high, which shows the shutdown and flag-only policies apart.

// File: rtl/tss_pkg.sv
package tss_pkg;
    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2,
        ST_OFF   = 2'd3
    } tss_state_e;

    localparam int unsigned SRC_BIAS_HI = 0;
    localparam int unsigned SRC_PD_HI   = 1;
    localparam int unsigned SRC_PD_LO   = 2;
    localparam int unsigned SRC_BIAS_UV = 3;
    localparam int unsigned SRC_EXT_REF = 4;
endpackage

// File: rtl/tss_sync.sv
module tss_sync #(
    parameter int unsigned       WIDTH   = 8,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                stab_q <= RST_VAL[b];
            end else begin
                meta_q <= async_i[b];
                stab_q <= meta_q;
            end
        end
        assign sync_o[b] = stab_q;
    end
endmodule

// File: rtl/tss_qualify.sv
module tss_qualify #(
    parameter int unsigned NUM_SRC = 5,
    parameter int unsigned MODE_SRC = 4
) (
    input  logic [NUM_SRC-1:0] flags_i,
    input  logic               vset_mode_i,
    output logic [NUM_SRC-1:0] qual_o
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        if (s == MODE_SRC) begin : g_moded
            assign qual_o[s] = flags_i[s] & vset_mode_i;
        end else begin : g_plain
            assign qual_o[s] = flags_i[s];
        end
    end
endmodule

// File: rtl/tss_ctrl.sv
module tss_ctrl
    import tss_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 5,
    parameter int unsigned INIT_CYCLES = 3125000,
    parameter int unsigned HOLD_CYCLES = 125
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dis_i,
    input  logic               report_only_i,
    input  logic [NUM_SRC-1:0] qual_i,
    output logic               fault_o,
    output logic               bias_en_o,
    output logic               mod_en_o,
    output logic [NUM_SRC-1:0] src_o,
    output logic               in_init_o
);
    localparam int unsigned MAXC = (INIT_CYCLES > HOLD_CYCLES) ? INIT_CYCLES : HOLD_CYCLES;
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] INIT_LAST = CW'(INIT_CYCLES - 1);
    localparam logic [CW-1:0] HOLD_MIN  = CW'(HOLD_CYCLES);

    typedef struct packed {
        tss_state_e         st;
        logic [CW-1:0]      cnt;
        logic               fault;
        logic               bias_en;
        logic               mod_en;
        logic [NUM_SRC-1:0] src;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  any_fault;
    logic  run_on;

    assign any_fault = |qual_i;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_INIT: begin
                if (dis_i) begin
                    r_d.st  = ST_OFF;
                    r_d.cnt = '0;
                end else if (r_q.cnt == INIT_LAST) begin
                    r_d.cnt = '0;
                    if (any_fault) begin
                        r_d.st  = ST_FAULT;
                        r_d.src = qual_i;
                    end else begin
                        r_d.st = ST_RUN;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_RUN: begin
                if (dis_i) begin
                    r_d.st = ST_OFF;
                end else if (any_fault) begin
                    r_d.st  = ST_FAULT;
                    r_d.src = qual_i;
                    r_d.cnt = '0;
                end
            end
            ST_OFF: begin
                if (!dis_i) begin
                    r_d.st  = ST_INIT;
                    r_d.cnt = '0;
                end
            end
            ST_FAULT: begin
                if (dis_i) begin
                    if (r_q.cnt < HOLD_MIN) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end else if (r_q.cnt >= HOLD_MIN) begin
                    r_d.st  = ST_INIT;
                    r_d.cnt = '0;
                    r_d.src = '0;
                end else begin
                    r_d.cnt = '0;
                end
            end
            default: begin
                r_d.st  = ST_INIT;
                r_d.cnt = '0;
            end
        endcase

        run_on = (r_d.st == ST_RUN) ||
                 ((r_d.st == ST_FAULT) && report_only_i && !dis_i);
        r_d.fault   = (r_d.st == ST_FAULT);
        r_d.bias_en = run_on;
        r_d.mod_en  = run_on;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_INIT, cnt: '0, fault: 1'b0, bias_en: 1'b0,
                     mod_en: 1'b0, src: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign fault_o   = r_q.fault;
    assign bias_en_o = r_q.bias_en;
    assign mod_en_o  = r_q.mod_en;
    assign src_o     = r_q.src;
    assign in_init_o = (r_q.st == ST_INIT);
endmodule

// File: rtl/tx_safety_supervisor.sv
module tx_safety_supervisor
    import tss_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 5,
    parameter int unsigned INIT_CYCLES = 3125000,
    parameter int unsigned HOLD_CYCLES = 125
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_disable_i,
    input  logic [NUM_SRC-1:0] fault_flags_i,
    input  logic               vset_mode_i,
    input  logic               report_only_i,
    output logic               fault_o,
    output logic               bias_en_o,
    output logic               mod_en_o,
    output logic [NUM_SRC-1:0] fault_src_o
);
    localparam int unsigned SW = NUM_SRC + 3;
    localparam logic [SW-1:0] SYNC_RST = SW'(1) << NUM_SRC;

    logic [SW-1:0]      raw_vec;
    logic [SW-1:0]      syn_vec;
    logic [NUM_SRC-1:0] flags_s;
    logic [NUM_SRC-1:0] qual;
    logic               dis_s;
    logic               vm_s;
    logic               ro_s;
    logic               in_init;

    assign raw_vec = {report_only_i, vset_mode_i, tx_disable_i, fault_flags_i};
    assign flags_s = syn_vec[NUM_SRC-1:0];
    assign dis_s   = syn_vec[NUM_SRC];
    assign vm_s    = syn_vec[NUM_SRC+1];
    assign ro_s    = syn_vec[NUM_SRC+2];

    tss_sync #(.WIDTH(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_vec),
        .sync_o  (syn_vec)
    );

    tss_qualify #(.NUM_SRC(NUM_SRC), .MODE_SRC(SRC_EXT_REF)) u_qual (
        .flags_i     (flags_s),
        .vset_mode_i (vm_s),
        .qual_o      (qual)
    );

    tss_ctrl #(
        .NUM_SRC     (NUM_SRC),
        .INIT_CYCLES (INIT_CYCLES),
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .dis_i         (dis_s),
        .report_only_i (ro_s),
        .qual_i        (qual),
        .fault_o       (fault_o),
        .bias_en_o     (bias_en_o),
        .mod_en_o      (mod_en_o),
        .src_o         (fault_src_o),
        .in_init_o     (in_init)
    );
endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
    parameter int unsigned NUM_SRC = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dis_s,
    input logic               ro_s,
    input logic               in_init,
    input logic               fault,
    input logic               bias_en,
    input logic               mod_en,
    input logic [NUM_SRC-1:0] src
);
    AST_DISABLE_KILLS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        dis_s |=> (!bias_en && !mod_en)); // R1
    AST_NO_EN_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        in_init |-> (!bias_en && !mod_en)); // R2
    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && dis_s) |=> fault); // R3
    AST_FAULT_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !$past(ro_s)) |-> (!bias_en && !mod_en)); // R4
    AST_CLEAR_BY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> (!$past(dis_s) && $past(dis_s, 2))); // R5
    AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && $past(fault)) |-> $stable(src)); // R8
    AST_SRC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (src != '0)); // R8
    AST_ENTRY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> !$past(dis_s)); // R9
endmodule

bind tx_safety_supervisor tss_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dis_s   (dis_s),
    .ro_s    (ro_s),
    .in_init (in_init),
    .fault   (fault_o),
    .bias_en (bias_en_o),
    .mod_en  (mod_en_o),
    .src     (fault_src_o)
);

// File: tb/tx_safety_supervisor_tb.sv
module tx_safety_supervisor_tb;
    localparam int INIT = 20;
    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dis = 1'b0;
    logic [4:0] flags = 5'd0;
    logic       vm = 1'b0;
    logic       ro = 1'b0;
    logic       fault_o, bias_en_o, mod_en_o;
    logic [4:0] fault_src_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tx_safety_supervisor #(.NUM_SRC(5), .INIT_CYCLES(INIT), .HOLD_CYCLES(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_disable_i(dis), .fault_flags_i(flags),
        .vset_mode_i(vm), .report_only_i(ro), .fault_o(fault_o),
        .bias_en_o(bias_en_o), .mod_en_o(mod_en_o), .fault_src_o(fault_src_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: inputs delayed through a queue, mode as integer
    logic [7:0] hist[$];
    int         m_mode;   // 0 init, 1 run, 2 latched, 3 disabled
    int         m_cnt;
    int         m_fault, m_en, m_src;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{8'h20, 8'h20};
            m_mode = 0; m_cnt = 0; m_fault = 0; m_en = 0; m_src = 0;
        end else begin
            logic [7:0] w;
            int qual, d, r;
            w = hist[0];
            d = w[5];
            r = w[7];
            qual = w[4:0] & (w[6] ? 5'h1F : 5'h0F);
            if (m_mode == 0) begin
                if (d) begin m_mode = 3; m_cnt = 0; end
                else if (m_cnt == INIT - 1) begin
                    m_cnt = 0;
                    if (qual != 0) begin m_mode = 2; m_src = qual; end
                    else m_mode = 1;
                end else m_cnt++;
            end else if (m_mode == 1) begin
                if (d) m_mode = 3;
                else if (qual != 0) begin m_mode = 2; m_src = qual; m_cnt = 0; end
            end else if (m_mode == 3) begin
                if (!d) begin m_mode = 0; m_cnt = 0; end
            end else begin
                if (d) begin if (m_cnt < HOLD) m_cnt++; end
                else if (m_cnt >= HOLD) begin m_mode = 0; m_cnt = 0; m_src = 0; end
                else m_cnt = 0;
            end
            m_fault = (m_mode == 2);
            m_en = (m_mode == 1) || (m_mode == 2 && r && !d);
            void'(hist.pop_front());
            hist.push_back({ro, vm, dis, flags});
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 fault_o vs model", fault_o, m_fault);
            check("R4 bias_en_o vs model", bias_en_o, m_en);
            check("R4 mod_en_o vs model", mod_en_o, m_en);
            check("R8 fault_src_o vs model", fault_src_o, m_src);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_pulse(input int hi);
        dis = 1'b1; tick(hi); dis = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired (all requirements)");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        tick(3);
        check("R2 reset fault_o", fault_o, 0);
        check("R2 reset enables", bias_en_o | mod_en_o, 0);
        rst_n = 1'b1;
        tick(INIT / 2);
        check("R2 enables off during init", bias_en_o, 0);
        tick(INIT + 6);
        check("R2 enables on after init", bias_en_o & mod_en_o, 1);

        // R7 / R1: disable latency
        dis = 1'b1; tick(2);
        check("R7 enables still on after 2 edges", bias_en_o, 1);
        tick(1);
        check("R1 enables off after disable", bias_en_o | mod_en_o, 0);
        dis = 1'b0; tick(INIT + 6);

        // R7 / R3 / R8: single-cycle fault pulse on bit 0
        flags = 5'h01; tick(1); flags = 5'h00; tick(1);
        check("R7 fault not yet visible", fault_o, 0);
        tick(1);
        check("R7 fault visible at edge k+2", fault_o, 1);
        check("R4 enables off on fault", bias_en_o | mod_en_o, 0);
        tick(10);
        check("R3 fault stays latched", fault_o, 1);
        check("R8 source bit 0", fault_src_o, 5'h01);

        // R5: short pulse does not clear
        clear_pulse(HOLD - 2); tick(8);
        check("R5 short pulse keeps fault", fault_o, 1);
        // R5: long pulse clears, then R9: flag during init ignored
        clear_pulse(HOLD + 2); tick(4);
        check("R5 fault cleared", fault_o, 0);
        check("R5 source cleared", fault_src_o, 0);
        flags = 5'h02; tick(3); flags = 5'h00;
        tick(INIT + 6);
        check("R9 flag during init ignored", fault_o, 0);
        check("R2 enables back on", bias_en_o, 1);

        // R6: bit 4 needs voltage-setpoint mode
        flags = 5'h10; tick(6); flags = 5'h00; tick(2);
        check("R6 bit4 ignored without mode", fault_o, 0);
        vm = 1'b1; tick(3);
        flags = 5'h10; tick(5); flags = 5'h00; tick(1);
        check("R6 bit4 latches in mode", fault_o, 1);
        check("R6 source bit 4", fault_src_o, 5'h10);

        // R4: report-only keeps enables on
        ro = 1'b1;
        clear_pulse(HOLD + 1); tick(INIT + 6);
        flags = 5'h04; tick(1); flags = 5'h00; tick(4);
        check("R4 report-only fault flagged", fault_o, 1);
        check("R4 report-only enables on", bias_en_o & mod_en_o, 1);
        dis = 1'b1; tick(3);
        check("R1 disable overrides report-only", bias_en_o | mod_en_o, 0);
        tick(HOLD + 1); dis = 1'b0; ro = 1'b0; tick(INIT + 6);

        // R9: flag ignored while disabled
        dis = 1'b1; tick(3); flags = 5'h02; tick(2); flags = 5'h00; tick(3);
        dis = 1'b0; tick(INIT + 6);
        check("R9 flag while disabled ignored", fault_o, 0);

        // R9: flag held across end of init latches immediately
        flags = 5'h08; tick(6);
        check("R3 bit3 latched", fault_o, 1);
        clear_pulse(HOLD + 2); tick(INIT + 6);
        check("R9 held flag latches after init", fault_o, 1);
        check("R9 source bit 3", fault_src_o, 5'h08);
        flags = 5'h00; tick(4);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule